// File: doc/BRIEF.md
# DMA Dispatcher Control and Status Register Block

This block is the host-facing register file of a descriptor-driven DMA dispatcher. The host reads live engine and queue state through it: busy, empty and full flags, fill levels and sequence numbers. It programs the dispatcher through a control word, which holds a stop request, a stop on error, a stop on early termination, a global interrupt enable and a halt of descriptor processing. It clears latched conditions by writing ones to the status word.

The engine reports three single-cycle events: transfer error, early termination and completion. Each event latches an interrupt-pending flag. An error or early-termination event also latches a halt condition when the matching stop policy is enabled. Writing the reset bit of the control word starts a soft reset of fixed length. During that interval the block drives the engine's reset request, shows a "resetting" status bit for the host to poll, and refuses new control words and events. When the interval ends, the stop bit, both halt flags and the pending flag are cleared.

Top module: `dma_dispatch_csr`

## Requirements
- R1: Reads at byte offset 0x08 return the write fill level in bits 31:16 and the read fill level in bits 15:0. Offset 0x0C returns the response fill level in bits 15:0 and zero above. Offset 0x10 returns the write sequence number in bits 31:16 and the read sequence number in bits 15:0. Any other offset, including unaligned ones, reads zero.
- R2: Status word (offset 0x00) bits 0 to 4 show, in the same cycle, engine busy, descriptor queue empty, descriptor queue full, response queue empty and response queue full.
- R3: The control word (offset 0x04) has these fields: bit 0 stop, bit 2 stop on error, bit 3 stop on early termination, bit 4 global interrupt enable, bit 5 halt descriptor processing. These bits read back as written. Bit 1 reads as the resetting state. `descHalt` follows bit 5.
- R4: Status bits 7 (halted on error), 8 (halted on early termination) and 9 (interrupt pending) clear when a one is written to them. Writing zero to them, or writing anything to status bits 0 to 6, changes nothing.
- R5: A completion, error or early-termination event sets the pending flag on the next clock edge. A set and a write-one-clear in the same cycle leave the flag set.
- R6: `irq` is high exactly when the pending flag is set and global interrupt enable is 1.
- R7: An error event while stop on error is 1 sets status bits 7 and 5. With stop on error at 0, the event sets only the pending flag.
- R8: An early-termination event while stop on early termination is 1 sets status bits 8 and 5. With that policy at 0, the event sets only the pending flag.
- R9: Status bit 5 and `engStop` are high when the control stop bit, the error halt or the early-termination halt is set.
- R10: A control write with bit 1 set, made while no reset is running, raises status bit 6 and `engReset` from the next edge for exactly RESET_CYCLES cycles.
- R11: When the reset interval ends, the control stop bit, both halt flags and the pending flag are cleared. The other control bits keep their values.
- R12: While a reset runs, control writes and engine events have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte offset for reads and writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| engBusy | input | 1 | Engine busy flag |
| descEmpty | input | 1 | Descriptor queue empty |
| descFull | input | 1 | Descriptor queue full |
| respEmpty | input | 1 | Response queue empty |
| respFull | input | 1 | Response queue full |
| rdFill | input | FILL_W | Read descriptor fill level |
| wrFill | input | FILL_W | Write descriptor fill level |
| respFill | input | FILL_W | Response queue fill level |
| rdSeq | input | SEQ_W | Read sequence number |
| wrSeq | input | SEQ_W | Write sequence number |
| evtError | input | 1 | Transfer error event pulse |
| evtEarly | input | 1 | Early termination event pulse |
| evtDone | input | 1 | Transfer completion event pulse |
| engStop | output | 1 | Stop request to the engine |
| engReset | output | 1 | Reset request, high while resetting |
| descHalt | output | 1 | Halt descriptor processing |
| irq | output | 1 | Interrupt request |

## Verification
Read data and the status bits that mirror engine inputs are combinational, so they are due in the same cycle as the input and are sampled half a period after the inputs settle. A write or event takes effect on the next rising edge: latched flags, control fields, `irq` and `engStop` must change exactly one edge later. `engReset` must stay high for RESET_CYCLES edges after the starting write. The bench drives stimulus just after each rising edge and advances a behavioural reference on the rising edge. It compares every output and the currently addressed register at each falling edge, so an effect that arrives one cycle early or late is reported.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;

  typedef enum logic [2:0] {
    SEL_STATUS,
    SEL_CTRL,
    SEL_FILL,
    SEL_RESP,
    SEL_SEQ,
    SEL_NONE
  } rd_sel_e;

  typedef struct packed {
    logic    ctrlLoad;
    logic    clrHaltErr;
    logic    clrHaltEarly;
    logic    clrPend;
    logic    resetBusy;
    logic    resetFinish;
    rd_sel_e rdSel;
  } csr_strobe_t;

  localparam int OFS_STATUS = 'h00;
  localparam int OFS_CTRL   = 'h04;
  localparam int OFS_FILL   = 'h08;
  localparam int OFS_RESP   = 'h0C;
  localparam int OFS_SEQ    = 'h10;

  localparam int CB_STOP     = 0;
  localparam int CB_RESET    = 1;
  localparam int CB_SOE      = 2;
  localparam int CB_SOET     = 3;
  localparam int CB_GIE      = 4;
  localparam int CB_STOPDESC = 5;

  localparam int SB_HALTERR   = 7;
  localparam int SB_HALTEARLY = 8;
  localparam int SB_PEND      = 9;

endpackage

// File: rtl/dmacsr_ctrl.sv
module dmacsr_ctrl
  import dmacsr_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int RESET_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrResetBit,
  input  logic [2:0]        wrClrBits,
  output csr_strobe_t       strobe
);

  localparam int CNT_W = $clog2(RESET_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESET_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_FILL   = ADDR_W'(OFS_FILL);
  localparam logic [ADDR_W-1:0] A_RESP   = ADDR_W'(OFS_RESP);
  localparam logic [ADDR_W-1:0] A_SEQ    = ADDR_W'(OFS_SEQ);

  logic             rstBusy;
  logic [CNT_W-1:0] rstCnt;
  logic             wrStatus;
  logic             wrCtrl;
  logic             startReset;
  logic             lastCycle;

  assign wrStatus   = regWrEn && (regAddr == A_STATUS);
  assign wrCtrl     = regWrEn && (regAddr == A_CTRL) && !rstBusy;
  assign startReset = wrCtrl && wrResetBit;
  assign lastCycle  = rstBusy && (rstCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstBusy <= 1'b0;
      rstCnt  <= '0;
    end else if (rstBusy) begin
      rstCnt <= rstCnt - CNT_LAST;
      if (lastCycle) rstBusy <= 1'b0;
    end else if (startReset) begin
      rstBusy <= 1'b1;
      rstCnt  <= CNT_LOAD;
    end
  end

  always_comb begin
    strobe              = '0;
    strobe.ctrlLoad     = wrCtrl;
    strobe.clrHaltErr   = wrStatus && wrClrBits[0];
    strobe.clrHaltEarly = wrStatus && wrClrBits[1];
    strobe.clrPend      = wrStatus && wrClrBits[2];
    strobe.resetBusy    = rstBusy;
    strobe.resetFinish  = lastCycle;
    unique case (regAddr)
      A_STATUS: strobe.rdSel = SEL_STATUS;
      A_CTRL:   strobe.rdSel = SEL_CTRL;
      A_FILL:   strobe.rdSel = SEL_FILL;
      A_RESP:   strobe.rdSel = SEL_RESP;
      A_SEQ:    strobe.rdSel = SEL_SEQ;
      default:  strobe.rdSel = SEL_NONE;
    endcase
  end

  // R10: a reset request accepted while idle starts the interval
  assert_reset_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_CTRL && wrResetBit && !rstBusy) |=> rstBusy);

  // R10: the interval does not end before its last cycle
  assert_reset_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rstBusy && rstCnt != CNT_LAST) |=> rstBusy);

  // R10: the interval ends after its last cycle
  assert_reset_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rstBusy && rstCnt == CNT_LAST) |=> !rstBusy);

endmodule

// File: rtl/dmacsr_datapath.sv
module dmacsr_datapath
  import dmacsr_pkg::*;
#(
  parameter int FILL_W = 16,
  parameter int SEQ_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  csr_strobe_t       strobe,
  input  logic [4:0]        ctrlData,
  input  logic              engBusy,
  input  logic              descEmpty,
  input  logic              descFull,
  input  logic              respEmpty,
  input  logic              respFull,
  input  logic [FILL_W-1:0] rdFill,
  input  logic [FILL_W-1:0] wrFill,
  input  logic [FILL_W-1:0] respFill,
  input  logic [SEQ_W-1:0]  rdSeq,
  input  logic [SEQ_W-1:0]  wrSeq,
  input  logic              evtError,
  input  logic              evtEarly,
  input  logic              evtDone,
  output logic [31:0]       regRdData,
  output logic              engStop,
  output logic              engReset,
  output logic              descHalt,
  output logic              irq
);

  logic ctrlStop, stopOnErr, stopOnEarly, intEnable, stopDesc;
  logic haltErr, haltEarly, pend;
  logic evtLive, setErr, setEarly, setPend, stopped;
  logic [31:0] statusWord, ctrlWord;

  assign evtLive  = !strobe.resetBusy;
  assign setPend  = evtLive && (evtError || evtEarly || evtDone);
  assign setErr   = evtLive && evtError && stopOnErr;
  assign setEarly = evtLive && evtEarly && stopOnEarly;
  assign stopped  = ctrlStop || haltErr || haltEarly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlStop    <= 1'b0;
      stopOnErr   <= 1'b0;
      stopOnEarly <= 1'b0;
      intEnable   <= 1'b0;
      stopDesc    <= 1'b0;
    end else if (strobe.resetFinish) begin
      ctrlStop <= 1'b0;
    end else if (strobe.ctrlLoad) begin
      ctrlStop    <= ctrlData[0];
      stopOnErr   <= ctrlData[1];
      stopOnEarly <= ctrlData[2];
      intEnable   <= ctrlData[3];
      stopDesc    <= ctrlData[4];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltErr   <= 1'b0;
      haltEarly <= 1'b0;
      pend      <= 1'b0;
    end else if (strobe.resetFinish) begin
      haltErr   <= 1'b0;
      haltEarly <= 1'b0;
      pend      <= 1'b0;
    end else begin
      if (setErr) haltErr <= 1'b1;
      else if (strobe.clrHaltErr) haltErr <= 1'b0;
      if (setEarly) haltEarly <= 1'b1;
      else if (strobe.clrHaltEarly) haltEarly <= 1'b0;
      if (setPend) pend <= 1'b1;
      else if (strobe.clrPend) pend <= 1'b0;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[0] = engBusy;
    statusWord[1] = descEmpty;
    statusWord[2] = descFull;
    statusWord[3] = respEmpty;
    statusWord[4] = respFull;
    statusWord[5] = stopped;
    statusWord[6] = strobe.resetBusy;
    statusWord[SB_HALTERR]   = haltErr;
    statusWord[SB_HALTEARLY] = haltEarly;
    statusWord[SB_PEND]      = pend;
    ctrlWord = '0;
    ctrlWord[CB_STOP]     = ctrlStop;
    ctrlWord[CB_RESET]    = strobe.resetBusy;
    ctrlWord[CB_SOE]      = stopOnErr;
    ctrlWord[CB_SOET]     = stopOnEarly;
    ctrlWord[CB_GIE]      = intEnable;
    ctrlWord[CB_STOPDESC] = stopDesc;
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_STATUS: regRdData = statusWord;
      SEL_CTRL:   regRdData = ctrlWord;
      SEL_FILL:   regRdData = {16'(wrFill), 16'(rdFill)};
      SEL_RESP:   regRdData = {16'h0, 16'(respFill)};
      SEL_SEQ:    regRdData = {16'(wrSeq), 16'(rdSeq)};
      default:    regRdData = '0;
    endcase
  end

  assign engStop  = stopped;
  assign engReset = strobe.resetBusy;
  assign descHalt = stopDesc;
  assign irq      = pend && intEnable;

  // R5: any live event latches the pending flag
  assert_evt_pend_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((evtError || evtEarly || evtDone) && !strobe.resetBusy) |=> pend);

  // R4: a clear with no event drops the pending flag
  assert_pend_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrPend && !(evtError || evtEarly || evtDone)) |=> !pend);

  // R7: error under stop-on-error halts the engine
  assert_halt_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evtError && stopOnErr && !strobe.resetBusy) |=> (haltErr && engStop));

  // R8: early termination under its policy halts the engine
  assert_halt_early_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evtEarly && stopOnEarly && !strobe.resetBusy) |=> (haltEarly && engStop));

  // R11: end of reset leaves no stop, halt or pending state
  assert_reset_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.resetFinish |=> (!pend && !haltErr && !haltEarly && !engStop));

  // R12: control fields hold while a reset is running
  assert_ctrl_frozen_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.resetBusy && !strobe.resetFinish) |=> $stable({stopOnErr, stopOnEarly, intEnable, stopDesc}));

endmodule

// File: rtl/dma_dispatch_csr.sv
module dma_dispatch_csr
  import dmacsr_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int FILL_W       = 16,
  parameter int SEQ_W        = 16,
  parameter int RESET_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              engBusy,
  input  logic              descEmpty,
  input  logic              descFull,
  input  logic              respEmpty,
  input  logic              respFull,
  input  logic [FILL_W-1:0] rdFill,
  input  logic [FILL_W-1:0] wrFill,
  input  logic [FILL_W-1:0] respFill,
  input  logic [SEQ_W-1:0]  rdSeq,
  input  logic [SEQ_W-1:0]  wrSeq,
  input  logic              evtError,
  input  logic              evtEarly,
  input  logic              evtDone,
  output logic              engStop,
  output logic              engReset,
  output logic              descHalt,
  output logic              irq
);

  csr_strobe_t strobe;

  dmacsr_ctrl #(
    .ADDR_W       (ADDR_W),
    .RESET_CYCLES (RESET_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .wrResetBit (regWrData[CB_RESET]),
    .wrClrBits  ({regWrData[SB_PEND], regWrData[SB_HALTEARLY], regWrData[SB_HALTERR]}),
    .strobe     (strobe)
  );

  dmacsr_datapath #(
    .FILL_W (FILL_W),
    .SEQ_W  (SEQ_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ctrlData  ({regWrData[CB_STOPDESC], regWrData[CB_GIE], regWrData[CB_SOET],
                 regWrData[CB_SOE], regWrData[CB_STOP]}),
    .engBusy   (engBusy),
    .descEmpty (descEmpty),
    .descFull  (descFull),
    .respEmpty (respEmpty),
    .respFull  (respFull),
    .rdFill    (rdFill),
    .wrFill    (wrFill),
    .respFill  (respFill),
    .rdSeq     (rdSeq),
    .wrSeq     (wrSeq),
    .evtError  (evtError),
    .evtEarly  (evtEarly),
    .evtDone   (evtDone),
    .regRdData (regRdData),
    .engStop   (engStop),
    .engReset  (engReset),
    .descHalt  (descHalt),
    .irq       (irq)
  );

endmodule

// File: tb/dma_dispatch_csr_tb.sv
module dma_dispatch_csr_tb;

  localparam int CLK_PERIOD   = 10;
  localparam int ADDR_W       = 5;
  localparam int FILL_W       = 16;
  localparam int SEQ_W        = 16;
  localparam int RESET_CYCLES = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic engBusy = 1'b0, descEmpty = 1'b1, descFull = 1'b0, respEmpty = 1'b1, respFull = 1'b0;
  logic [FILL_W-1:0] rdFill = '0, wrFill = '0, respFill = '0;
  logic [SEQ_W-1:0] rdSeq = '0, wrSeq = '0;
  logic evtError = 1'b0, evtEarly = 1'b0, evtDone = 1'b0;
  logic engStop, engReset, descHalt, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference state
  bit mStop, mSoe, mSoet, mGie, mStopDesc, mHaltErr, mHaltEarly, mPend;
  int mLeft = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_dispatch_csr #(
    .ADDR_W(ADDR_W), .FILL_W(FILL_W), .SEQ_W(SEQ_W), .RESET_CYCLES(RESET_CYCLES)
  ) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .engBusy(engBusy), .descEmpty(descEmpty), .descFull(descFull),
    .respEmpty(respEmpty), .respFull(respFull), .rdFill(rdFill), .wrFill(wrFill),
    .respFill(respFill), .rdSeq(rdSeq), .wrSeq(wrSeq), .evtError(evtError),
    .evtEarly(evtEarly), .evtDone(evtDone), .engStop(engStop), .engReset(engReset),
    .descHalt(descHalt), .irq(irq)
  );

  always @(posedge clk) begin
    bit wrS, wrC;
    wrS = regWrEn && (regAddr == 5'h00);
    wrC = regWrEn && (regAddr == 5'h04);
    if (!rstN) begin
      {mStop, mSoe, mSoet, mGie, mStopDesc, mHaltErr, mHaltEarly, mPend} = '0;
      mLeft = 0;
    end else if (mLeft > 0) begin
      if (wrS && regWrData[7]) mHaltErr = 0;
      if (wrS && regWrData[8]) mHaltEarly = 0;
      if (wrS && regWrData[9]) mPend = 0;
      mLeft = mLeft - 1;
      if (mLeft == 0) begin
        mStop = 0; mHaltErr = 0; mHaltEarly = 0; mPend = 0;
      end
    end else begin
      if (wrS && regWrData[7]) mHaltErr = 0;
      if (wrS && regWrData[8]) mHaltEarly = 0;
      if (wrS && regWrData[9]) mPend = 0;
      if (evtDone || evtError || evtEarly) mPend = 1;
      if (evtError && mSoe) mHaltErr = 1;
      if (evtEarly && mSoet) mHaltEarly = 1;
      if (wrC) begin
        mStop = regWrData[0]; mSoe = regWrData[2]; mSoet = regWrData[3];
        mGie = regWrData[4]; mStopDesc = regWrData[5];
        if (regWrData[1]) mLeft = RESET_CYCLES;
      end
    end
  end

  function automatic logic [31:0] expRead(logic [ADDR_W-1:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      5'h00: v = {22'h0, mPend, mHaltEarly, mHaltErr, (mLeft > 0), (mStop | mHaltErr | mHaltEarly),
                  respFull, respEmpty, descFull, descEmpty, engBusy};
      5'h04: v = {26'h0, mStopDesc, mGie, mSoet, mSoe, (mLeft > 0), mStop};
      5'h08: v = {wrFill, rdFill};
      5'h0C: v = {16'h0, respFill};
      5'h10: v = {wrSeq, rdSeq};
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      string rtag;
      if (regAddr == 5'h00) rtag = "R2 R4 R5 R7 R8 R9 status";
      else if (regAddr == 5'h04) rtag = "R3 R11 R12 control";
      else rtag = "R1 map";
      check(rtag, regRdData, expRead(regAddr));
      check("R6 irq", 32'(irq), 32'(mPend & mGie));
      check("R9 engStop", 32'(engStop), 32'(mStop | mHaltErr | mHaltEarly));
      check("R10 engReset", 32'(engReset), 32'(mLeft > 0));
      check("R3 descHalt", 32'(descHalt), 32'(mStopDesc));
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic look(logic [ADDR_W-1:0] a);
    regAddr = a;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    rstN = 1'b1;
    // reset state: status and control read zero apart from live flags
    look(5'h00); look(5'h04);
    // R1: fill, response fill, sequence and unmapped offsets
    rdFill = 16'h0012; wrFill = 16'hA0C3; respFill = 16'h0007; rdSeq = 16'h1234; wrSeq = 16'hBEEF;
    look(5'h08); look(5'h0C); look(5'h10); look(5'h14); look(5'h06); look(5'h1C);
    // R2: live status inputs
    regAddr = 5'h00;
    engBusy = 1; descEmpty = 0; descFull = 1; tick();
    respEmpty = 0; respFull = 1; tick();
    engBusy = 0; descFull = 0; respFull = 0; descEmpty = 1; respEmpty = 1; tick();
    // R3: control readback
    wr(5'h04, 32'h0000_003D); look(5'h04);
    wr(5'h04, 32'h0000_001C); look(5'h04);
    // R5 R6: completion sets pending, irq gated by enable
    regAddr = 5'h00; evtDone = 1; tick(); evtDone = 0; tick();
    wr(5'h04, 32'h0000_000C); look(5'h00);
    wr(5'h04, 32'h0000_001C); look(5'h00);
    // R4: writes to non-clearable bits and zeros change nothing
    wr(5'h00, 32'h0000_007F); look(5'h00);
    wr(5'h00, 32'h0000_0200); look(5'h00);
    // R5: set wins over a clear in the same cycle
    evtDone = 1; wr(5'h00, 32'h0000_0200); evtDone = 0; look(5'h00);
    wr(5'h00, 32'h0000_0200);
    // R7: error with and without stop on error
    regAddr = 5'h00; evtError = 1; tick(); evtError = 0; tick();
    wr(5'h00, 32'h0000_0280); look(5'h00);
    wr(5'h04, 32'h0000_0010);
    regAddr = 5'h00; evtError = 1; tick(); evtError = 0; tick();
    wr(5'h00, 32'h0000_0200);
    // R8: early termination with and without its policy
    regAddr = 5'h00; evtEarly = 1; tick(); evtEarly = 0; tick();
    wr(5'h04, 32'h0000_0018);
    regAddr = 5'h00; evtEarly = 1; tick(); evtEarly = 0; tick();
    wr(5'h00, 32'h0000_0100); look(5'h00);
    // R9: plain stop bit drives engStop
    wr(5'h04, 32'h0000_0015); look(5'h00);
    // R10 R11 R12: soft reset sequence
    regAddr = 5'h00; evtError = 1; tick(); evtError = 0;
    wr(5'h04, 32'h0000_0033);
    look(5'h04);
    wr(5'h04, 32'h0000_0001);
    regAddr = 5'h00; evtDone = 1; evtEarly = 1; tick(); evtDone = 0; evtEarly = 0;
    look(5'h04);
    tick(RESET_CYCLES);
    look(5'h00); look(5'h04);
    // reset starts cleanly from idle a second time
    wr(5'h04, 32'h0000_0002);
    regAddr = 5'h00; tick(RESET_CYCLES + 2);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule